// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Target

This block is a target on a two-wire I2C/SMBus-style bus running at up to 400 kHz. It gives a host access to a small bank of 16-bit registers. It is clocked by the system clock. It samples SCL and SDA through a two-flop synchronizer and pulls SDA low through a single output. It never holds SCL low.

The target's bus address is a fixed four-bit type code followed by three strap pins, so eight such targets can share one bus. An 8-bit pointer chooses which register a data transfer reaches. A write transaction always carries a pointer byte and may then carry a 16-bit word. A read transaction returns the word at the pointer, high byte first. The pointer keeps its value between transactions. A host that keeps polling one register can therefore read it without sending the pointer again.

The register bank sits outside the block and is reached through a plain index/read-data/write-strobe port. A parameter table marks each register as readable, writable or both, and the target enforces it.

Top module: `ptr_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 0011 followed by strap bits [2:0]. It acknowledges by pulling SDA low for the ninth clock of that byte. Bit 0 of the address byte selects read (1) or write (0).
- R2: An address byte that does not match is not acknowledged. Until the next START, the target then neither drives SDA nor issues writes, whatever bytes follow.
- R3: After reset the pointer is 0x00, so the register index output is 0, and SDA is released.
- R4: In a write transaction, the first byte after the address becomes the pointer and is acknowledged. A transaction that stops after that byte changes only the pointer and issues no register write.
- R5: Two further bytes in a write transaction form one word, first byte in bits [15:8]. They produce exactly one single-cycle write strobe carrying that word at the pointed register. Every byte is acknowledged.
- R6: A read transaction with no pointer byte returns the word at the pointer held from earlier transactions. The high byte comes first, and each byte goes out MSB first.
- R7: A write of a pointer byte, then a repeated START, then a read address returns the word at the new pointer.
- R8: With the default attributes, registers 0 and 7 are read-only, register 6 is write-only, and registers 1 to 5 are read/write. Pointer values of 8 and above select no register. A write to a non-writable target is acknowledged but produces no strobe. A read of a non-readable target returns 0x0000.
- R9: After a read byte, an ACK from the host makes the target send the next byte, alternating high and low halves. A NACK ends the read and SDA is released.
- R10: The target changes SDA only while SCL is low.
- R11: A STOP returns the target to idle with SDA released. Bytes clocked on an idle bus are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Low three address bits |
| reg_idx_o | output | 3 | Index of the register the pointer selects |
| reg_rdata_i | input | 16 | Read data of the indexed register |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 16 | Word to write, valid with the strobe |

## Verification
Each bus edge reaches the logic through two synchronizer flops and one edge-compare flop. SDA output changes and the write strobe therefore appear three system cycles after the SCL falling edge that triggers them. The bench host keeps SCL low for at least fourteen cycles after every falling edge and samples SDA halfway through the high phase, well after any such change has settled. The write strobe is compared on every falling clock edge against a queue of writes predicted by a behavioural model. Read words and acknowledges are compared against the model once each transaction ends.

// File: rtl/ptr_i2c_target.sv
module ptr_i2c_target #(
  parameter int               NREG      = 8,
  parameter logic [3:0]       TYPE_CODE = 4'b0011,
  parameter logic [NREG-1:0]  RD_OK     = 8'b1011_1111,
  parameter logic [NREG-1:0]  WR_OK     = 8'b0111_1110,
  localparam int              AW        = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull_o,
  input  logic [2:0]    strap_i,
  output logic [AW-1:0] reg_idx_o,
  input  logic [15:0]   reg_rdata_i,
  output logic          reg_wr_o,
  output logic [15:0]   reg_wdata_o
);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_PTR, ST_WDATA, ST_RDATA} st_t;

  logic [2:0]  scl_q, sda_q;
  st_t         st;
  logic [3:0]  bitcnt;
  logic [7:0]  rx, tx, ptr, hi;
  logic [15:0] word, wdata_q;
  logic        bsel, ack_pull, tx_en, mack, wr_q;

  wire s_scl = scl_q[1];
  wire p_scl = scl_q[2];
  wire s_sda = sda_q[1];
  wire p_sda = sda_q[2];

  wire scl_rise = s_scl & ~p_scl;
  wire scl_fall = ~s_scl & p_scl;
  wire start_c  = s_scl & p_scl & p_sda & ~s_sda;
  wire stop_c   = s_scl & p_scl & ~p_sda & s_sda;

  wire          ptr_ok   = int'(ptr) < NREG;
  wire [AW-1:0] idx      = ptr[AW-1:0];
  wire [15:0]   rd_word  = (ptr_ok && RD_OK[idx]) ? reg_rdata_i : 16'h0000;
  wire          addr_hit = rx[7:1] == {TYPE_CODE, strap_i};

  assign reg_idx_o   = idx;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign sda_pull_o  = ack_pull | (tx_en & (bitcnt != 4'd9) & ~tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      rx       <= '0;
      tx       <= '0;
      ptr      <= '0;
      hi       <= '0;
      word     <= '0;
      wdata_q  <= '0;
      bsel     <= 1'b0;
      ack_pull <= 1'b0;
      tx_en    <= 1'b0;
      mack     <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (start_c) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        ack_pull <= 1'b0;
        tx_en    <= 1'b0;
        bsel     <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        bitcnt   <= '0;
        ack_pull <= 1'b0;
        tx_en    <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            if (st != ST_RDATA) rx <= {rx[6:0], s_sda};
          end else if (bitcnt == 4'd9 && st == ST_RDATA) begin
            mack <= ~s_sda;
          end
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            if (st != ST_RDATA) begin
              ack_pull <= 1'b1;
              case (st)
                ST_ADDR: begin
                  if (!addr_hit) begin
                    st       <= ST_IDLE;
                    ack_pull <= 1'b0;
                    bitcnt   <= '0;
                  end else if (rx[0]) begin
                    st    <= ST_RDATA;
                    tx_en <= 1'b0;
                    bsel  <= 1'b0;
                  end else begin
                    st <= ST_PTR;
                  end
                end
                ST_PTR: begin
                  ptr  <= rx;
                  st   <= ST_WDATA;
                  bsel <= 1'b0;
                end
                ST_WDATA: begin
                  if (!bsel) begin
                    hi   <= rx;
                    bsel <= 1'b1;
                  end else begin
                    bsel    <= 1'b0;
                    wr_q    <= ptr_ok && WR_OK[idx];
                    wdata_q <= {hi, rx};
                  end
                end
                default: ;
              endcase
            end
          end else if (bitcnt == 4'd9) begin
            ack_pull <= 1'b0;
            bitcnt   <= '0;
            if (st == ST_RDATA) begin
              if (!tx_en || mack) begin
                tx_en <= 1'b1;
                bsel  <= ~bsel;
                if (!bsel) begin
                  word <= rd_word;
                  tx   <= rd_word[15:8];
                end else begin
                  tx <= word[7:0];
                end
              end else begin
                tx_en <= 1'b0;
                st    <= ST_IDLE;
              end
            end
          end else if (tx_en) begin
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  a_r10_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (s_scl && $past(s_scl)) |-> $stable(sda_pull_o));

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull_o);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o);

  a_r3_ptr_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reg_idx_o == '0 && !sda_pull_o));

  a_r2_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !wr_q);

endmodule

// File: tb/ptr_i2c_target_tb.sv
module ptr_i2c_target_tb;
  localparam int T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0]  strap = 3'b010;
  logic        sda_pull, reg_wr;
  logic [2:0]  reg_idx;
  logic [15:0] reg_rdata, reg_wdata;
  logic [15:0] bank [8];
  logic [15:0] mdl  [8];
  logic [18:0] exp_wr [$];
  int          n_cmp = 0, n_bad = 0;

  wire sda_line = m_sda & ~sda_pull;
  wire [7:0] rd_ok = 8'b1011_1111;
  wire [7:0] wr_ok = 8'b0111_1110;

  always #5 clk = ~clk;

  ptr_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(strap), .reg_idx_o(reg_idx),
    .reg_rdata_i(reg_rdata), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata)
  );

  assign reg_rdata = bank[reg_idx];
  always @(posedge clk) if (reg_wr) bank[reg_idx] <= reg_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      if (exp_wr.size() == 0) check("R8 unexpected write strobe", {13'd0, reg_idx, reg_wdata}, 32'hFFFF_FFFF);
      else check("R5 write strobe", {13'd0, reg_idx, reg_wdata}, {13'd0, exp_wr.pop_front()});
    end
  end

  task automatic hw(input int n); repeat (n) @(negedge clk); endtask

  task automatic wbit(input logic b);
    m_sda = b; hw(T); m_scl = 1'b1; hw(T); m_scl = 1'b0; hw(4);
  endtask

  task automatic rbit(output logic v);
    m_sda = 1'b1; hw(T); m_scl = 1'b1; hw(T/2); v = sda_line; hw(T/2); m_scl = 1'b0; hw(4);
  endtask

  task automatic bstart; m_sda = 1'b1; hw(T); m_scl = 1'b1; hw(T); m_sda = 1'b0; hw(T); m_scl = 1'b0; hw(4); endtask
  task automatic bstop;  m_sda = 1'b0; hw(T); m_scl = 1'b1; hw(T); m_sda = 1'b1; hw(T); endtask

  task automatic send(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(v);
    ack = ~v;
  endtask

  task automatic recv(input logic host_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) rbit(b[i]);
    wbit(~host_ack);
  endtask

  function automatic logic [15:0] exp_read(input logic [7:0] p);
    return (p < 8 && rd_ok[p[2:0]]) ? mdl[p[2:0]] : 16'h0000;
  endfunction

  function automatic logic [6:0] dev();
    return {4'b0011, strap};
  endfunction

  task automatic model_write(input logic [7:0] p, input logic [15:0] d);
    if (p < 8 && wr_ok[p[2:0]]) begin
      exp_wr.push_back({p[2:0], d});
      mdl[p[2:0]] = d;
    end
  endtask

  task automatic read_cur(output logic a, output logic [15:0] w);
    logic [7:0] h, l;
    bstart; send({dev(), 1'b1}, a); recv(1'b1, h); recv(1'b0, l); bstop;
    w = {h, l};
  endtask

  task automatic read_at(input logic [7:0] p, output logic a, output logic [15:0] w);
    logic a1, a2, a3;
    logic [7:0] h, l;
    bstart; send({dev(), 1'b0}, a1); send(p, a2);
    bstart; send({dev(), 1'b1}, a3); recv(1'b1, h); recv(1'b0, l); bstop;
    a = a1 & a2 & a3; w = {h, l};
  endtask

  task automatic write_word(input logic [7:0] p, input logic [15:0] d, output logic a);
    logic a1, a2, a3, a4;
    model_write(p, d);
    bstart; send({dev(), 1'b0}, a1); send(p, a2); send(d[15:8], a3); send(d[7:0], a4); bstop;
    a = a1 & a2 & a3 & a4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic a;
    logic [15:0] w;
    logic [7:0] h, l, h2;
    for (int i = 0; i < 8; i++) begin
      bank[i] = 16'hA000 + 16'(i) * 16'h0111;
      mdl[i]  = bank[i];
    end
    hw(10); rst_n = 1'b1; hw(5);
    check("R3 index after reset", {29'd0, reg_idx}, 0);
    check("R3 SDA released after reset", {31'd0, sda_pull}, 0);

    read_cur(a, w);
    check("R1 read address ack", {31'd0, a}, 1);
    check("R6 read at reset pointer", {16'd0, w}, {16'd0, exp_read(8'h00)});

    bstart; send({4'b0011, 3'b101, 1'b0}, a);
    check("R2 strap mismatch not acked", {31'd0, a}, 0);
    send(8'h00, a); check("R2 ignored byte", {31'd0, a}, 0);
    send(8'h11, a); check("R2 ignored byte 2", {31'd0, a}, 0);
    bstop;
    bstart; send({4'b0100, strap, 1'b0}, a);
    check("R2 type code mismatch not acked", {31'd0, a}, 0);
    bstop;

    bstart; send({dev(), 1'b0}, a); check("R1 write address ack", {31'd0, a}, 1);
    send(8'h03, a); check("R4 pointer byte ack", {31'd0, a}, 1);
    bstop; hw(5);
    check("R4 pointer latched", {29'd0, reg_idx}, 3);
    check("R4 no write from pointer-only", exp_wr.size(), 0);
    read_cur(a, w);
    check("R6 sticky pointer read", {16'd0, w}, {16'd0, exp_read(8'h03)});

    write_word(8'h02, 16'hBEEF, a);
    check("R5 write acks", {31'd0, a}, 1);
    check("R5 write strobe seen", exp_wr.size(), 0);
    read_at(8'h02, a, w);
    check("R7 read after repeated START", {16'd0, w}, 16'hBEEF);
    read_at(8'h05, a, w);
    check("R7 read new pointer", {16'd0, w}, {16'd0, exp_read(8'h05)});

    write_word(8'h00, 16'h1234, a);
    check("R8 read-only write acked", {31'd0, a}, 1);
    read_at(8'h00, a, w);
    check("R8 read-only unchanged", {16'd0, w}, {16'd0, exp_read(8'h00)});
    read_at(8'h06, a, w);
    check("R8 write-only reads zero", {16'd0, w}, 0);
    write_word(8'h06, 16'h5A5A, a);
    check("R8 write-only accepts write", exp_wr.size(), 0);
    read_at(8'h20, a, w);
    check("R8 out-of-range reads zero", {16'd0, w}, 0);
    write_word(8'h20, 16'h7777, a);
    check("R8 out-of-range write acked", {31'd0, a}, 1);

    bstart; send({dev(), 1'b0}, a); send(8'h04, a);
    bstart; send({dev(), 1'b1}, a);
    recv(1'b1, h); recv(1'b1, l); recv(1'b0, h2);
    check("R9 continued read word", {16'd0, h, l}, {16'd0, exp_read(8'h04)});
    check("R9 third byte is high half again", {24'd0, h2}, {24'd0, exp_read(8'h04) >> 8});
    hw(6);
    check("R9 SDA released after NACK", {31'd0, sda_pull}, 0);
    bstop;

    bstart; send({dev(), 1'b0}, a); send(8'h01, a); send(8'hC3, a); bstop;
    hw(4);
    check("R11 released after STOP mid-word", {31'd0, sda_pull}, 0);
    send({dev(), 1'b1}, a);
    check("R11 idle bus byte not acked", {31'd0, a}, 0);
    bstop;

    strap = 3'b101;
    bstart; send({4'b0011, 3'b010, 1'b1}, a); bstop;
    check("R1 old strap address not acked", {31'd0, a}, 0);
    read_at(8'h01, a, w);
    check("R1 new strap address acked", {31'd0, a}, 1);
    check("R1 R6 read via new address", {16'd0, w}, {16'd0, exp_read(8'h01)});
    check("R10 R5 no pending writes", exp_wr.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule